// File: doc/BRIEF.md
# Subtree Level Match Unit

This block is a single level of a multibit-trie longest-prefix lookup for IP addresses. The address is cut into fixed-width chunks of `STRIDE` bits. Level `LEVEL` owns every prefix whose length lies between `(LEVEL-1)*STRIDE` and `LEVEL*STRIDE-1`. Prefixes are grouped into subtrees. A subtree is named by the address bits above this level's chunk (its tag). The level keeps a small bank of tag registers. Each register has a bitmap row with one bit per trie node inside the subtree, which gives `2^STRIDE-1` bits per row, and a count of the prefixes it holds.

On a search, the tag of the key is compared against all live registers at once. The path that the key's chunk traces through the matching subtree is then examined, and the deepest set node is reported. The result is a hit flag, the matched prefix length and a next-hop memory pointer. The pointer is the register index concatenated with the node index. Node indexing is heap-style: at depth `d`, the node index is `2^d - 1` plus the value of the top `d` bits of the chunk.

Updates add or delete one prefix. A new tag takes the lowest free register. A register whose count falls to zero is released. The next-hop store and the choice between levels sit outside this block.

Top module: `trie_level_match`

## Requirements
- R1: After reset no subtree is stored, `ready` is high, `res_valid` is low, and any search returns a miss.
- R2: A search accepted while `ready` is high gives `res_valid` one cycle later. An update accepted while `ready` is high drops `ready` for one cycle, and `upd_done` pulses in the second cycle after acceptance. Requests presented while `ready` is low are ignored.
- R3: A search hits only when the key's top `(LEVEL-1)*STRIDE` bits equal the tag of a live register. Otherwise `res_hit` is 0.
- R4: Within the matching subtree, the result is the deepest set node on the key's path. `res_len` equals `(LEVEL-1)*STRIDE + depth`. If no node on the path is set, the search misses.
- R5: `res_ptr` is `{register index, node index}`, where node index = `2^d - 1 +` (top `d` bits of the chunk that follows the tag).
- R6: Adding a prefix whose tag is not stored places it in the lowest-numbered free register.
- R7: Adding a prefix with a new tag when no register is free raises `upd_err` and leaves all stored state unchanged.
- R8: Adding a prefix that is already stored raises no error and leaves the prefix count unchanged, so a single delete then removes it.
- R9: A delete clears the node bit and decrements the count. When the count reaches zero the register is freed, and the next new tag may reuse it.
- R10: Deleting a prefix that is not stored (unknown tag, or node bit clear) raises `upd_err` and changes nothing.
- R11: An update whose length lies outside `[(LEVEL-1)*STRIDE, LEVEL*STRIDE-1]` raises `upd_err` and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| srch_valid | input | 1 | Search request |
| srch_addr | input | ADDR_W | Search key |
| ready | output | 1 | High when a search or update can be accepted |
| res_valid | output | 1 | Search result strobe |
| res_hit | output | 1 | Match found at this level |
| res_len | output | LEN_W | Matched prefix length |
| res_ptr | output | IDX_W+NODE_W | Next-hop pointer {register, node} |
| upd_valid | input | 1 | Update request |
| upd_del | input | 1 | 1 = delete, 0 = add |
| upd_addr | input | ADDR_W | Prefix bits, left aligned |
| upd_len | input | LEN_W | Prefix length |
| upd_done | output | 1 | Update completion pulse |
| upd_err | output | 1 | Update rejected (with upd_done) |

## Verification
Searches are run against subtrees holding prefixes at several depths. Keys that share a path with set nodes at different depths show whether the deepest node wins. Keys that branch off early show whether off-path nodes are ignored. Keys with unknown tags exercise the tag compare. Update sequences fill the register bank, overflow it, repeat an add, delete down to an empty subtree and reuse the freed slot. These sequences separate correct counting from plain bit tracking. Out-of-range lengths and absent deletes confirm that rejected updates leave searches unchanged.

// File: rtl/trie_lvl_pkg.sv
// Shared types for the trie level match unit.
package trie_lvl_pkg;
    // Update kind carried from capture stage to apply stage.
    typedef enum logic {OP_ADD = 1'b0, OP_DEL = 1'b1} upd_op_e;
endpackage

// File: rtl/subtree_cam.sv
// Compares one key tag against all stored subtree tags in parallel.
// Assumes at most one live register holds a given tag (allocation keeps this).
module subtree_cam #(
    parameter int NSUB  = 4,
    parameter int TAG_W = 4,
    localparam int IDX_W = $clog2(NSUB)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSUB-1:0]             vld,
    input  logic [NSUB-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            key,
    output logic                        hit,
    output logic [IDX_W-1:0]            hit_idx
);
    logic [NSUB-1:0] hit_vec;

    // Per-register equality against the key.
    for (genvar g = 0; g < NSUB; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (tags[g] == key);
    end

    // Encode the matching register number.
    always_comb begin
        hit_idx = '0;
        for (int k = 0; k < NSUB; k++)
            if (hit_vec[k]) hit_idx = IDX_W'(k);
    end

    assign hit = |hit_vec;

    // R3: a tag never matches two live registers.
    p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/free_pick.sv
// Finds the lowest-numbered free subtree register.
module free_pick #(
    parameter int NSUB = 4,
    localparam int IDX_W = $clog2(NSUB)
) (
    input  logic [NSUB-1:0]  vld,
    output logic             any_free,
    output logic [IDX_W-1:0] free_idx
);
    // Scan from the top so the lowest free index wins.
    always_comb begin
        free_idx = '0;
        for (int k = NSUB - 1; k >= 0; k--)
            if (!vld[k]) free_idx = IDX_W'(k);
    end
    assign any_free = ~&vld;
endmodule

// File: rtl/path_walk.sv
// Walks the trie path of one stride chunk through a bitmap row and returns
// the deepest set node. Heap indexing: node(d) = 2^d - 1 + top d chunk bits.
module path_walk #(
    parameter int STRIDE = 4,
    localparam int ROW_W  = (1 << STRIDE) - 1,
    localparam int NODE_W = $clog2(ROW_W),
    localparam int DEP_W  = $clog2(STRIDE)
) (
    input  logic [ROW_W-1:0]  row,
    input  logic [STRIDE-1:0] chunk,
    output logic              found,
    output logic [DEP_W-1:0]  depth,
    output logic [NODE_W-1:0] node
);
    logic [STRIDE-1:0][NODE_W-1:0] path_node;

    // Node index at each depth along the path.
    for (genvar gd = 0; gd < STRIDE; gd++) begin : g_path
        assign path_node[gd] = NODE_W'((1 << gd) - 1) + NODE_W'(chunk >> (STRIDE - gd));
    end

    // Keep the deepest node whose bit is set.
    always_comb begin
        found = 1'b0;
        depth = '0;
        node  = '0;
        for (int d = 0; d < STRIDE; d++) begin
            if (row[path_node[d]]) begin
                found = 1'b1;
                depth = DEP_W'(d);
                node  = path_node[d];
            end
        end
    end
endmodule

// File: rtl/trie_level_match.sv
// One level of a multibit-trie longest-prefix lookup.
// Holds NSUB subtree registers (tag, bitmap row, prefix count).
// Search: 1-cycle registered result. Update: captured, applied next cycle;
// ready is low while an update is pending. Assumes LEVEL >= 2, STRIDE >= 2.
module trie_level_match #(
    parameter int ADDR_W = 16,
    parameter int STRIDE = 4,
    parameter int LEVEL  = 2,
    parameter int NSUB   = 4,
    localparam int TAG_W  = (LEVEL - 1) * STRIDE,
    localparam int ROW_W  = (1 << STRIDE) - 1,
    localparam int NODE_W = $clog2(ROW_W),
    localparam int DEP_W  = $clog2(STRIDE),
    localparam int IDX_W  = $clog2(NSUB),
    localparam int LEN_W  = $clog2(ADDR_W + 1),
    localparam int CNT_W  = $clog2(ROW_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    srch_valid,
    input  logic [ADDR_W-1:0]       srch_addr,
    output logic                    ready,
    output logic                    res_valid,
    output logic                    res_hit,
    output logic [LEN_W-1:0]        res_len,
    output logic [IDX_W+NODE_W-1:0] res_ptr,
    input  logic                    upd_valid,
    input  logic                    upd_del,
    input  logic [ADDR_W-1:0]       upd_addr,
    input  logic [LEN_W-1:0]        upd_len,
    output logic                    upd_done,
    output logic                    upd_err
);
    import trie_lvl_pkg::*;

    // Subtree register bank.
    logic [NSUB-1:0]             sub_vld;
    logic [NSUB-1:0][TAG_W-1:0]  sub_tag;
    logic [NSUB-1:0][ROW_W-1:0]  sub_row;
    logic [NSUB-1:0][CNT_W-1:0]  sub_cnt;

    // Captured update.
    logic                busy;
    upd_op_e             up_op;
    logic [ADDR_W-1:0]   up_addr;
    logic [LEN_W-1:0]    up_len;

    // Heap node index of depth d along chunk ch.
    function automatic logic [NODE_W-1:0] node_of(input logic [DEP_W-1:0] d,
                                                  input logic [STRIDE-1:0] ch);
        int unsigned di;
        di = int'(d);
        return NODE_W'((1 << di) - 1) + NODE_W'(ch >> (STRIDE - di));
    endfunction

    assign ready = !busy;

    // ---------------- search path ----------------
    logic               s_hit, s_found;
    logic [IDX_W-1:0]   s_idx;
    logic [DEP_W-1:0]   s_depth;
    logic [NODE_W-1:0]  s_node;

    subtree_cam #(.NSUB(NSUB), .TAG_W(TAG_W)) u_cam_srch (
        .clk(clk), .rst_n(rst_n), .vld(sub_vld), .tags(sub_tag),
        .key(srch_addr[ADDR_W-1 -: TAG_W]), .hit(s_hit), .hit_idx(s_idx));

    path_walk #(.STRIDE(STRIDE)) u_walk (
        .row(sub_row[s_idx]), .chunk(srch_addr[ADDR_W-TAG_W-1 -: STRIDE]),
        .found(s_found), .depth(s_depth), .node(s_node));

    // ---------------- update path ----------------
    logic               u_hit, u_any_free, len_ok, bit_set, err_c;
    logic [IDX_W-1:0]   u_idx, f_idx;
    logic [DEP_W-1:0]   u_depth;
    logic [NODE_W-1:0]  u_node;

    subtree_cam #(.NSUB(NSUB), .TAG_W(TAG_W)) u_cam_upd (
        .clk(clk), .rst_n(rst_n), .vld(sub_vld), .tags(sub_tag),
        .key(up_addr[ADDR_W-1 -: TAG_W]), .hit(u_hit), .hit_idx(u_idx));

    free_pick #(.NSUB(NSUB)) u_free (
        .vld(sub_vld), .any_free(u_any_free), .free_idx(f_idx));

    // Decode node, range and error for the captured update.
    always_comb begin
        len_ok  = (int'(up_len) >= TAG_W) && (int'(up_len) < TAG_W + STRIDE);
        u_depth = DEP_W'(up_len - LEN_W'(TAG_W));
        u_node  = node_of(u_depth, up_addr[ADDR_W-TAG_W-1 -: STRIDE]);
        bit_set = u_hit && sub_row[u_idx][u_node];
        if (!len_ok)
            err_c = 1'b1;
        else if (up_op == OP_ADD)
            err_c = !u_hit && !u_any_free;
        else
            err_c = !bit_set;
    end

    // Capture updates, apply them, and register search results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_vld   <= '0;
            sub_tag   <= '0;
            sub_row   <= '0;
            sub_cnt   <= '0;
            busy      <= 1'b0;
            up_op     <= OP_ADD;
            up_addr   <= '0;
            up_len    <= '0;
            upd_done  <= 1'b0;
            upd_err   <= 1'b0;
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_len   <= '0;
            res_ptr   <= '0;
        end else begin
            upd_done  <= busy;
            upd_err   <= busy && err_c;
            res_valid <= srch_valid && !busy;
            if (!busy && upd_valid) begin
                busy    <= 1'b1;
                up_op   <= upd_del ? OP_DEL : OP_ADD;
                up_addr <= upd_addr;
                up_len  <= upd_len;
            end
            if (busy) begin
                busy <= 1'b0;
                if (!err_c) begin
                    if (up_op == OP_ADD) begin
                        if (u_hit && !bit_set) begin
                            sub_row[u_idx][u_node] <= 1'b1;
                            sub_cnt[u_idx]         <= sub_cnt[u_idx] + 1'b1;
                        end else if (!u_hit) begin
                            sub_vld[f_idx] <= 1'b1;
                            sub_tag[f_idx] <= up_addr[ADDR_W-1 -: TAG_W];
                            sub_row[f_idx] <= ROW_W'(1) << u_node;
                            sub_cnt[f_idx] <= CNT_W'(1);
                        end
                    end else begin
                        sub_cnt[u_idx] <= sub_cnt[u_idx] - 1'b1;
                        if (sub_cnt[u_idx] == CNT_W'(1)) begin
                            sub_vld[u_idx] <= 1'b0;
                            sub_row[u_idx] <= '0;
                        end else begin
                            sub_row[u_idx][u_node] <= 1'b0;
                        end
                    end
                end
            end
            if (srch_valid && !busy) begin
                res_hit <= s_hit && s_found;
                res_len <= (s_hit && s_found) ? LEN_W'(TAG_W) + LEN_W'(s_depth) : '0;
                res_ptr <= (s_hit && s_found) ? {s_idx, s_node} : '0;
            end
        end
    end

    // R2: search result follows acceptance by one cycle.
    p_srch_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_valid && ready) |=> res_valid);
    // R2: an accepted update blocks the next cycle and completes after it.
    p_upd_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && ready) |=> !ready ##1 upd_done);
    // R4: a reported length lies within this level's span.
    p_len_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> (int'(res_len) >= TAG_W && int'(res_len) < TAG_W + STRIDE));
    // R7: a rejected update leaves register occupancy untouched.
    p_err_keeps_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_err |-> $stable(sub_vld));
    for (genvar g = 0; g < NSUB; g++) begin : g_chk
        // R9: a free register holds nothing.
        p_free_is_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !sub_vld[g] |-> (sub_row[g] == '0 && sub_cnt[g] == '0));
        // R9: a live register counts at least one prefix.
        p_live_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            sub_vld[g] |-> (sub_cnt[g] != '0 && sub_row[g] != '0));
    end
endmodule

// File: tb/trie_level_match_test.sv
// Directed bench: one task per scenario, each checking its own results.
module trie_level_match_test;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 5;
    localparam int PTR_W  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic srch_valid = 1'b0;
    logic [ADDR_W-1:0] srch_addr = '0;
    logic ready, res_valid, res_hit, upd_done, upd_err;
    logic [LEN_W-1:0] res_len;
    logic [PTR_W-1:0] res_ptr;
    logic upd_valid = 1'b0;
    logic upd_del = 1'b0;
    logic [ADDR_W-1:0] upd_addr = '0;
    logic [LEN_W-1:0] upd_len = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    trie_level_match uut (
        .clk(clk), .rst_n(rst_n), .srch_valid(srch_valid), .srch_addr(srch_addr),
        .ready(ready), .res_valid(res_valid), .res_hit(res_hit), .res_len(res_len),
        .res_ptr(res_ptr), .upd_valid(upd_valid), .upd_del(upd_del),
        .upd_addr(upd_addr), .upd_len(upd_len), .upd_done(upd_done), .upd_err(upd_err));

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Pointer = register*16 + node (4-bit node field).
    function automatic int ptr(input int reg_i, input int node);
        return reg_i * 16 + node;
    endfunction

    // Search one key and compare the registered result.
    task automatic search(input string tag, input logic [15:0] a,
                          input int hit, input int len, input int p);
        @(negedge clk);
        srch_valid = 1'b1; srch_addr = a;
        @(posedge clk);
        @(negedge clk);
        srch_valid = 1'b0;
        check({tag, " res_valid"}, int'(res_valid), 1);
        check({tag, " hit"}, int'(res_hit), hit);
        if (hit != 0) begin
            check({tag, " len"}, int'(res_len), len);
            check({tag, " ptr"}, int'(res_ptr), p);
        end
    endtask

    // Issue one update and check its timing and error flag.
    task automatic update(input string tag, input bit del, input logic [15:0] a,
                          input int len, input int exp_err);
        @(negedge clk);
        upd_valid = 1'b1; upd_del = del; upd_addr = a; upd_len = LEN_W'(len);
        @(posedge clk);
        @(negedge clk);
        upd_valid = 1'b0;
        check({tag, " R2 ready low"}, int'(ready), 0);
        check({tag, " R2 done early"}, int'(upd_done), 0);
        @(posedge clk);
        @(negedge clk);
        check({tag, " R2 done"}, int'(upd_done), 1);
        check({tag, " err"}, int'(upd_err), exp_err);
    endtask

    task automatic t_reset;
        check("R1 ready", int'(ready), 1);
        check("R1 res_valid", int'(res_valid), 0);
        search("R1 empty", 16'hA500, 0, 0, 0);
    endtask

    task automatic t_longest;
        update("R6 add A/5", 1'b0, 16'hA500, 5, 0);       // reg0 node1
        search("R4 A5 d1", 16'hA500, 1, 5, ptr(0, 1));
        update("R4 add A/7", 1'b0, 16'hA500, 7, 0);       // node 7+2=9
        search("R4 R5 A5 d3", 16'hA500, 1, 7, ptr(0, 9));
        search("R4 off path", 16'hAD00, 0, 0, 0);
        update("R4 add A/4", 1'b0, 16'hA000, 4, 0);       // node0
        search("R4 R5 AD d0", 16'hAD00, 1, 4, ptr(0, 0));
        search("R3 wrong tag", 16'hB500, 0, 0, 0);
    endtask

    task automatic t_alloc_full;
        update("R6 add 3/6", 1'b0, 16'h3C00, 6, 0);       // reg1 node 3+3=6
        search("R5 R6 3C", 16'h3C00, 1, 6, ptr(1, 6));
        update("R8 dup 3/6", 1'b0, 16'h3C00, 6, 0);
        update("R6 add 5/4", 1'b0, 16'h5000, 4, 0);       // reg2
        update("R6 add 7/4", 1'b0, 16'h7000, 4, 0);       // reg3
        search("R6 7x", 16'h7F00, 1, 4, ptr(3, 0));
        update("R7 full", 1'b0, 16'h9000, 4, 1);
        search("R7 no alloc", 16'h9000, 0, 0, 0);
        search("R7 others kept", 16'h5000, 1, 4, ptr(2, 0));
    endtask

    task automatic t_free_reuse;
        update("R8 R9 del 3/6", 1'b1, 16'h3C00, 6, 0);
        search("R8 R9 gone", 16'h3C00, 0, 0, 0);
        update("R9 reuse", 1'b0, 16'h9000, 4, 0);         // reg1 freed
        search("R9 reuse idx", 16'h9000, 1, 4, ptr(1, 0));
    endtask

    task automatic t_bad;
        update("R10 bit absent", 1'b1, 16'h5000, 7, 1);
        update("R10 tag absent", 1'b1, 16'hB000, 4, 1);
        search("R10 5x intact", 16'h5000, 1, 4, ptr(2, 0));
        update("R11 len short", 1'b0, 16'hA000, 3, 1);
        update("R11 len long", 1'b0, 16'hA500, 8, 1);
        search("R11 A5 intact", 16'hA500, 1, 7, ptr(0, 9));
        update("R11 del len long", 1'b1, 16'hA500, 8, 1);
        search("R11 A5 still", 16'hA500, 1, 7, ptr(0, 9));
    endtask

    task automatic t_partial_delete;
        update("R9 del A/7", 1'b1, 16'hA500, 7, 0);
        search("R9 R4 shorter", 16'hA500, 1, 5, ptr(0, 1));
        update("R9 del A/5", 1'b1, 16'hA500, 5, 0);
        search("R9 R4 root", 16'hA500, 1, 4, ptr(0, 0));
    endtask

    task automatic t_ignored;
        // R2: a search offered while ready is low yields no result.
        @(negedge clk);
        upd_valid = 1'b1; upd_del = 1'b0; upd_addr = 16'h5000; upd_len = 5'd4;
        @(posedge clk);
        @(negedge clk);
        upd_valid = 1'b0;
        srch_valid = 1'b1; srch_addr = 16'h5000;
        @(posedge clk);
        @(negedge clk);
        srch_valid = 1'b0;
        check("R2 blocked search", int'(res_valid), 0);
        check("R2 dup done", int'(upd_done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_longest();
        t_alloc_full();
        t_free_reuse();
        t_bad();
        t_partial_delete();
        t_ignored();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule